// File: doc/BRIEF.md
# Second-Operand Shifter and Immediate Rotator

This block forms the second operand of a data-processing instruction from the instruction's packed 12-bit operand field. It is purely combinational. One mode-select input chooses between two interpretations of the field. In immediate mode, the block takes an 8-bit constant and rotates it right within a 32-bit word. In register mode, it takes a value read from the register file and applies one of four shift kinds. The shift amount comes either from a 5-bit field of the instruction or from the low byte of a second register value.

Besides the operand, the block returns a shifter carry. The downstream flag logic uses this carry for logical operations. It is the last bit moved out by the shift, or the incoming carry flag when nothing moves. Register reads, ALU execution, condition checks and flag writeback all live outside the block. The register indices inside the field (bits 3:0 for the shifted register and bits 11:8 for the amount register) are only used by the register file. The block receives the values that were read.

The design has no state, so it has no state machine. It is split into a field splitter, an immediate rotator and a register shifter. A final output select chooses between the rotator and the shifter.

Top module: `opnd2_shifter`

## Requirements
- R1: With `imm_sel`=1, the operand is field bits 7:0 zero-extended to 32 bits and rotated right by twice the value of field bits 11:8.
- R2: With `imm_sel`=1, the carry is `carry_in` when field bits 11:8 are zero, and otherwise bit 31 of the rotated operand.
- R3: With `imm_sel`=0, field bits 6:5 select the shift kind (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). Field bit 4 selects the amount source: 0 takes field bits 11:7, and 1 takes `rs_val[7:0]`. With bit 4 set, field bits 11:7 have no effect.
- R4: With `imm_sel`=0 and a shift amount of zero, the operand equals `rm_val` and the carry equals `carry_in`, for every shift kind.
- R5: Logical left by n in 1..32 gives `rm_val << n` with carry `rm_val[32-n]`. For n above 32, the operand is zero and the carry is zero.
- R6: Logical right by n in 1..32 gives `rm_val >> n` with carry `rm_val[n-1]`. For n above 32, the operand is zero and the carry is zero.
- R7: Arithmetic right by n in 1..31 shifts in copies of `rm_val[31]`, with carry `rm_val[n-1]`. For n of 32 or more, every operand bit and the carry equal `rm_val[31]`.
- R8: Rotate right by a nonzero n rotates `rm_val` by n mod 32, and the carry is bit 31 of the result. When n is a nonzero multiple of 32, the operand equals `rm_val` and the carry is `rm_val[31]`.
- R9: Bits 31:8 of `rs_val` never affect the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field | input | 12 | Packed second-operand field of the instruction |
| imm_sel | input | 1 | 1 = rotated-immediate mode, 0 = register mode |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register holding a shift amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Formed second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench goes after the amount boundaries where shifter designs usually break:
- A zero amount. A design that forgets the pass-through would return a rotate-by-32 or a shifted value together with a stale carry.
- Amounts of exactly 32, 33 and above for register-sourced amounts. A design that truncates the amount to five bits would wrap around instead of flushing to zero or to the sign bit.
- Rotates by nonzero multiples of 32, which must keep the operand unchanged but still report bit 31 as the carry.
- Upper bits of `rs_val` and of the field in register-amount mode. These are set to noise, so a design that used them would produce operands that drift.

In immediate mode, the bench checks a rotate field of zero against a nonzero one. A design that doubled the rotate wrongly or took the carry from the wrong place shows up there.

// File: rtl/opnd2_pkg.sv
package opnd2_pkg;

    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 12;
    localparam int IMM_W    = 8;
    localparam int ROT_W    = 4;
    localparam int AMT_W    = 5;
    localparam int RAMT_W   = 8;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [ROT_W-1:0] rot;
        logic [IMM_W-1:0] imm8;
        shift_kind_e      kind;
        logic             amt_from_reg;
        logic [AMT_W-1:0] amt_imm;
    } op2_fields_t;

endpackage

// File: rtl/opnd2_field_split.sv
module opnd2_field_split
    import opnd2_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output op2_fields_t        fld
);
    always_comb begin
        fld.imm8         = field[IMM_W-1:0];
        fld.rot          = field[FIELD_W-1:FIELD_W-ROT_W];
        fld.amt_from_reg = field[4];
        fld.kind         = shift_kind_e'(field[6:5]);
        fld.amt_imm      = field[FIELD_W-1:FIELD_W-AMT_W];
    end
endmodule

// File: rtl/opnd2_rot_imm.sv
module opnd2_rot_imm
    import opnd2_pkg::*;
(
    input  logic [IMM_W-1:0]  imm8,
    input  logic [ROT_W-1:0]  rot,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int SH_W = ROT_W + 1;

    logic [DATA_W-1:0] wide;
    logic [SH_W-1:0]   sh;
    logic [SH_W:0]     back;

    always_comb begin
        wide = {{(DATA_W-IMM_W){1'b0}}, imm8};
        sh   = {rot, 1'b0};
        back = (SH_W+1)'(DATA_W) - {1'b0, sh};
        res  = (wide >> sh) | (wide << back);
        cout = (rot == '0) ? cin : res[DATA_W-1];
    end
endmodule

// File: rtl/opnd2_reg_shift.sv
module opnd2_reg_shift
    import opnd2_pkg::*;
(
    input  logic [DATA_W-1:0] x,
    input  shift_kind_e       kind,
    input  logic [RAMT_W-1:0] amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int CL_W = $clog2(DATA_W + 2);
    localparam int RW   = $clog2(DATA_W);

    logic [CL_W-1:0]   n_log;
    logic [CL_W-1:0]   n_ari;
    logic [RW-1:0]     n_rot;
    logic [RW:0]       n_back;
    logic [DATA_W:0]   lsl_w;
    logic [DATA_W:0]   lsr_w;
    logic [DATA_W:0]   asr_w;
    logic [DATA_W-1:0] ror_v;

    always_comb begin
        n_log  = (amt > RAMT_W'(DATA_W + 1)) ? CL_W'(DATA_W + 1) : amt[CL_W-1:0];
        n_ari  = (amt > RAMT_W'(DATA_W))     ? CL_W'(DATA_W)     : amt[CL_W-1:0];
        n_rot  = amt[RW-1:0];
        n_back = (RW+1)'(DATA_W) - {1'b0, n_rot};
        lsl_w  = {1'b0, x} << n_log;
        lsr_w  = {x, 1'b0} >> n_log;
        asr_w  = (DATA_W+1)'($signed({x, 1'b0}) >>> n_ari);
        ror_v  = (x >> n_rot) | (x << n_back);
        if (amt == '0) begin
            res  = x;
            cout = cin;
        end else begin
            unique case (kind)
                SHK_LSL: begin res = lsl_w[DATA_W-1:0]; cout = lsl_w[DATA_W]; end
                SHK_LSR: begin res = lsr_w[DATA_W:1];   cout = lsr_w[0];      end
                SHK_ASR: begin res = asr_w[DATA_W:1];   cout = asr_w[0];      end
                default: begin res = ror_v;             cout = ror_v[DATA_W-1]; end
            endcase
        end
    end
endmodule

// File: rtl/opnd2_shifter.sv
module opnd2_shifter
    import opnd2_pkg::*;
(
    input  logic [FIELD_W-1:0] op_field,
    input  logic               imm_sel,
    input  logic [DATA_W-1:0]  rm_val,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  operand_out,
    output logic               carry_out
);
    op2_fields_t       fld;
    logic [RAMT_W-1:0] amt_sel;
    logic [DATA_W-1:0] imm_res;
    logic              imm_c;
    logic [DATA_W-1:0] reg_res;
    logic              reg_c;

    opnd2_field_split u_split (
        .field (op_field),
        .fld   (fld)
    );

    opnd2_rot_imm u_rot (
        .imm8 (fld.imm8),
        .rot  (fld.rot),
        .cin  (carry_in),
        .res  (imm_res),
        .cout (imm_c)
    );

    always_comb begin
        amt_sel = fld.amt_from_reg ? rs_val[RAMT_W-1:0]
                                   : {{(RAMT_W-AMT_W){1'b0}}, fld.amt_imm};
    end

    opnd2_reg_shift u_shift (
        .x    (rm_val),
        .kind (fld.kind),
        .amt  (amt_sel),
        .cin  (carry_in),
        .res  (reg_res),
        .cout (reg_c)
    );

    always_comb begin
        operand_out = imm_sel ? imm_res : reg_res;
        carry_out   = imm_sel ? imm_c   : reg_c;
    end
endmodule

// File: rtl/opnd2_shifter_chk.sv
module opnd2_shifter_chk (
    input logic [11:0] op_field,
    input logic        imm_sel,
    input logic [31:0] rm_val,
    input logic [31:0] rs_val,
    input logic        carry_in,
    input logic [31:0] operand_out,
    input logic        carry_out
);
    logic [7:0] amt;

    always_comb begin
        amt = op_field[4] ? rs_val[7:0] : {3'b000, op_field[11:7]};
        if (imm_sel && op_field[11:8] == 4'h0) begin
            AST_IMM_NO_ROT: assert (operand_out == {24'h0, op_field[7:0]} && carry_out == carry_in) else $error("imm no-rotate"); // R2
        end
        if (imm_sel) begin
            AST_IMM_BITS_KEPT: assert ($countones(operand_out) == $countones(op_field[7:0])) else $error("imm popcount"); // R1
        end
        if (!imm_sel && amt == 8'h00) begin
            AST_ZERO_AMT_PASS: assert (operand_out == rm_val && carry_out == carry_in) else $error("zero pass"); // R4
        end
        if (!imm_sel && op_field[6:5] == 2'b00 && amt > 8'd32) begin
            AST_LSL_FLUSH: assert (operand_out == 32'h0 && !carry_out) else $error("lsl flush"); // R5
        end
        if (!imm_sel && op_field[6:5] == 2'b10 && amt >= 8'd32) begin
            AST_ASR_SIGN_FILL: assert (operand_out == {32{rm_val[31]}} && carry_out == rm_val[31]) else $error("asr fill"); // R7
        end
        if (!imm_sel && op_field[6:5] == 2'b11) begin
            AST_ROR_BITS_KEPT: assert ($countones(operand_out) == $countones(rm_val)) else $error("ror popcount"); // R8
        end
    end
endmodule

bind opnd2_shifter opnd2_shifter_chk u_chk (
    .op_field    (op_field),
    .imm_sel     (imm_sel),
    .rm_val      (rm_val),
    .rs_val      (rs_val),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out)
);

// File: tb/opnd2_shifter_tb.sv
module opnd2_shifter_tb;
    logic        clk = 1'b0;
    logic [11:0] op_field = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand_out;
    logic        carry_out;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    opnd2_shifter u_dut (
        .op_field    (op_field),
        .imm_sel     (imm_sel),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .carry_in    (carry_in),
        .operand_out (operand_out),
        .carry_out   (carry_out)
    );

    function automatic logic [32:0] ref_op2(input logic [11:0] f, input logic isel,
                                            input logic [31:0] rm, input logic [31:0] rs,
                                            input logic cin);
        logic [31:0] v;
        logic        c;
        int          n;
        if (isel) begin
            v = {24'h0, f[7:0]};
            for (int k = 0; k < 2 * int'(f[11:8]); k++) v = {v[0], v[31:1]};
            c = (f[11:8] == 4'h0) ? cin : v[31];
        end else begin
            n = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
            v = rm;
            c = cin;
            for (int k = 0; k < n; k++) begin
                case (f[6:5])
                    2'b00:   begin c = v[31]; v = {v[30:0], 1'b0}; end
                    2'b01:   begin c = v[0];  v = {1'b0, v[31:1]}; end
                    2'b10:   begin c = v[0];  v = {v[31], v[31:1]}; end
                    default: begin c = v[0];  v = {v[0], v[31:1]}; end
                endcase
            end
        end
        return {c, v};
    endfunction

    task automatic apply(input logic [11:0] f, input logic isel, input logic [31:0] rm,
                         input logic [31:0] rs, input logic cin, input string req);
        logic [32:0] exp;
        @(negedge clk);
        op_field = f; imm_sel = isel; rm_val = rm; rs_val = rs; carry_in = cin;
        exp = ref_op2(f, isel, rm, rs, cin);
        #2;
        n_vec++;
        if (operand_out !== exp[31:0] || carry_out !== exp[32]) begin
            n_bad++;
            $display("FAIL %s field=%h imm=%b rm=%h rs=%h cin=%b: got %h/%b expected %h/%b",
                     req, f, isel, rm, rs, cin, operand_out, carry_out, exp[31:0], exp[32]);
        end
    endtask

    // reg-mode field: amount-imm, kind, amount source
    function automatic logic [11:0] rfld(input int amt, input logic [1:0] kind, input logic src);
        return {amt[4:0], kind, src, 4'h3};
    endfunction

    task automatic t_reset_state();
        apply(12'h000, 1'b0, 32'h0, 32'h0, 1'b0, "R4 all-zero");
    endtask

    task automatic t_imm_rotate();
        apply(12'h00A, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b1, "R2 rot0 carry_in");
        apply(12'h00A, 1'b1, 32'h0, 32'h0, 1'b0, "R2 rot0 carry_in low");
        apply(12'h1FF, 1'b1, 32'h0, 32'h0, 1'b0, "R1 rot2");
        apply(12'h4C3, 1'b1, 32'h0, 32'h0, 1'b1, "R2 rot8 carry");
        for (int r = 0; r < 16; r++)
            apply({r[3:0], 8'hA5}, 1'b1, 32'h1234_5678, 32'h0, r[0], "R1 rotate sweep");
    endtask

    task automatic t_zero_amount();
        for (int k = 0; k < 4; k++) begin
            apply(rfld(0, k[1:0], 1'b0), 1'b0, 32'h8000_0001, 32'h0, 1'b1, "R4 imm amt 0");
            apply(rfld(5, k[1:0], 1'b1), 1'b0, 32'hC0FF_EE01, 32'hFFFF_FF00, 1'b0, "R4 reg amt 0");
        end
    endtask

    task automatic t_kind(input logic [1:0] kind, input logic [31:0] rm, input string req);
        for (int a = 1; a < 32; a++) apply(rfld(a, kind, 1'b0), 1'b0, rm, 32'h0, 1'b0, req);
        for (int a = 30; a < 70; a++) apply(rfld(0, kind, 1'b1), 1'b0, rm, a, 1'b1, req);
        apply(rfld(0, kind, 1'b1), 1'b0, rm, 32'h0000_00FF, 1'b1, req);
    endtask

    task automatic t_shifts();
        t_kind(2'b00, 32'h8000_0001, "R5 lsl");
        t_kind(2'b00, 32'h7FFF_FFFE, "R5 lsl");
        t_kind(2'b01, 32'h8000_0001, "R6 lsr");
        t_kind(2'b10, 32'h8000_00F1, "R7 asr neg");
        t_kind(2'b10, 32'h7000_0001, "R7 asr pos");
        t_kind(2'b11, 32'h8421_0F0F, "R8 ror");
        apply(rfld(0, 2'b11, 1'b1), 1'b0, 32'h8421_0F0E, 32'd64, 1'b0, "R8 ror 64");
        apply(rfld(0, 2'b11, 1'b1), 1'b0, 32'h0421_0F0F, 32'd32, 1'b1, "R8 ror 32");
    endtask

    task automatic t_field_decode();
        apply(12'h182, 1'b0, 32'h0000_00FF, 32'h0, 1'b0, "R3 lsl imm amt 3");
        apply({5'b10101, 2'b01, 1'b1, 4'h0}, 1'b0, 32'hF000_0000, 32'd4, 1'b0, "R3 reg amt ignores 11:7");
        apply({5'b00000, 2'b01, 1'b1, 4'h0}, 1'b0, 32'hF000_0000, 32'd4, 1'b0, "R3 reg amt ignores 11:7");
        apply({5'd4, 2'b10, 1'b0, 4'hF}, 1'b0, 32'hF000_0000, 32'd9, 1'b0, "R3 imm amt ignores rs");
    endtask

    task automatic t_rs_upper();
        apply(rfld(0, 2'b01, 1'b1), 1'b0, 32'hFFFF_0000, 32'hABCD_1204, 1'b0, "R9 rs upper noise");
        apply(rfld(0, 2'b00, 1'b1), 1'b0, 32'h0000_FFFF, 32'hFFFF_FF00, 1'b1, "R9 rs upper with zero low");
        apply(rfld(0, 2'b11, 1'b1), 1'b0, 32'h1357_9BDF, 32'h0100_0008, 1'b0, "R9 rs upper ror");
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_imm_rotate();
        t_zero_amount();
        t_shifts();
        t_field_decode();
        t_rs_upper();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule